// File: doc/BRIEF.md
# Stop-and-Go Slack Buffer Receiver

This block sits at the receiving end of a byte-wide switch input link. Each cycle the link may deliver one flit, which is written into a slack buffer. The switch core drains the buffer through a valid/ready handshake, one flit per cycle, in arrival order.

The block tracks buffer occupancy and drives a hysteresis pair of thresholds. Once occupancy climbs past the high mark, it asks the upstream side to send a stop control flit. Once occupancy later falls under the low mark, it asks for a go control flit. Each request is a one-cycle pulse with a type bit, issued only when the link state changes. The space above the high mark soaks up flits that are still in flight after a stop. If a flit arrives while the buffer is full, it is discarded and a sticky error flag is set.

Top module: `slack_rx`

## Requirements
- R1: After reset the buffer is empty, `out_valid_o` is 0, `ctl_req_o` is 0, `ctl_stop_o` is 0 (go state) and `ovf_o` is 0.
- R2: Flits are released in the order they were accepted. A flit offered while the buffer holds fewer than DEPTH (80) entries is accepted in that cycle.
- R3: `out_valid_o` is 1 exactly when the buffer is non-empty. While `out_valid_o` is 1 and `out_ready_i` is 0, `out_flit_o` holds its value.
- R4: In the go state, if the registered occupancy exceeds STOP_LVL (56), the next cycle shows `ctl_req_o`=1 with `ctl_stop_o`=1 (1 = stop).
- R5: In the stop state, if the registered occupancy falls below GO_LVL (40), the next cycle shows `ctl_req_o`=1 with `ctl_stop_o`=0 (0 = go).
- R6: `ctl_req_o` pulses for a single cycle, and only on a change of link state. `ctl_stop_o` keeps the current state between requests.
- R7: A flit offered while the buffer holds DEPTH entries is dropped, even if a flit leaves in the same cycle. `ovf_o` then rises and stays at 1 until reset.
- R8: A cycle that both accepts and releases a flit leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_flit_i | input | 8 | Flit from link |
| in_valid_i | input | 1 | Flit present on link this cycle |
| out_flit_o | output | 8 | Head flit toward switch core |
| out_valid_o | output | 1 | Head flit valid |
| out_ready_i | input | 1 | Switch core takes head flit |
| ctl_req_o | output | 1 | One-cycle request to send a control flit |
| ctl_stop_o | output | 1 | Control flit type / link state: 1 stop, 0 go |
| ovf_o | output | 1 | Sticky overflow error |

## Verification
The assertions take for granted that the core keeps `out_ready_i` meaningful in every cycle. They also take for granted that occupancy moves by at most one per cycle, so the two thresholds can never be crossed in back-to-back cycles. The stimulus covers both a well-behaved sender and a misbehaving one. In some phases the sender keeps pushing past the stop request until the buffer fills and overflows. In others, random valid/ready patterns sweep occupancy across both thresholds many times. The reset is asserted again mid-run to recheck the idle state.

// File: rtl/slack_pkg.sv
package slack_pkg;
  typedef enum logic {LINK_GO = 1'b0, LINK_STOP = 1'b1} link_st_e;
endpackage

// File: rtl/slack_fifo.sv
module slack_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 80,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  wr_data_i,
  input  logic          wr_en_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_C = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push, pop;

  assign full       = (cnt_q == FULL_C);
  assign push       = wr_en_i && !full;
  assign pop        = rd_valid_o && rd_ready_i;
  assign drop_o     = wr_en_i && full;
  assign rd_valid_o = (cnt_q != '0);
  assign rd_data_o  = mem_q[rd_ptr_q];
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
  p_head_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
  p_both_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_valid_o && rd_ready_i && !full) |=> $stable(cnt_q));
endmodule

// File: rtl/slack_flow_ctl.sv
module slack_flow_ctl
  import slack_pkg::*;
#(
  parameter int DEPTH    = 80,
  parameter int STOP_LVL = 56,
  parameter int GO_LVL   = 40,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          drop_i,
  output logic          req_o,
  output logic          stop_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] STOP_C = CW'(STOP_LVL);
  localparam logic [CW-1:0] GO_C   = CW'(GO_LVL);

  link_st_e st_q;
  logic     req_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LINK_GO;
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (st_q == LINK_GO && count_i > STOP_C) begin
        st_q  <= LINK_STOP;
        req_q <= 1'b1;
      end else if (st_q == LINK_STOP && count_i < GO_C) begin
        st_q  <= LINK_GO;
        req_q <= 1'b1;
      end
      if (drop_i) ovf_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign stop_o = (st_q == LINK_STOP);
  assign ovf_o  = ovf_q;

  p_stop_cross_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && stop_o) |-> ($past(count_i) > STOP_C));
  p_go_cross_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !stop_o) |-> ($past(count_i) < GO_C));
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  p_state_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> (req_o || $stable(stop_o)));
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/slack_rx.sv
module slack_rx #(
  parameter int W        = 8,
  parameter int DEPTH    = 80,
  parameter int STOP_LVL = 56,
  parameter int GO_LVL   = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_flit_i,
  input  logic         in_valid_i,
  output logic [W-1:0] out_flit_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic         ctl_req_o,
  output logic         ctl_stop_o,
  output logic         ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          drop;

  slack_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_data_i  (in_flit_i),
    .wr_en_i    (in_valid_i),
    .rd_data_o  (out_flit_o),
    .rd_valid_o (out_valid_o),
    .rd_ready_i (out_ready_i),
    .count_o    (count),
    .drop_o     (drop)
  );

  slack_flow_ctl #(.DEPTH(DEPTH), .STOP_LVL(STOP_LVL), .GO_LVL(GO_LVL)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count),
    .drop_i  (drop),
    .req_o   (ctl_req_o),
    .stop_o  (ctl_stop_o),
    .ovf_o   (ovf_o)
  );

  p_valid_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o);
endmodule

// File: tb/tb_slack_rx.sv
module tb_slack_rx;
  localparam int DEPTH = 80, STOP_LVL = 56, GO_LVL = 40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_flit = '0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] out_flit;
  logic       out_valid, ctl_req, ctl_stop, ovf;

  slack_rx #(.DEPTH(DEPTH), .STOP_LVL(STOP_LVL), .GO_LVL(GO_LVL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_flit_i(in_flit), .in_valid_i(in_valid),
    .out_flit_o(out_flit), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .ctl_req_o(ctl_req), .ctl_stop_o(ctl_stop), .ovf_o(ovf));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, reqs_seen = 0;
  logic [7:0] seq = '0;

  // reference model
  logic [7:0] q[$];
  bit m_stop, m_req, m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_stop = 0; m_req = 0; m_ovf = 0;
    end else begin
      int sz;
      bit pop, push;
      sz = q.size();
      m_req = 0;
      if (!m_stop && sz > STOP_LVL) begin m_stop = 1; m_req = 1; end
      else if (m_stop && sz < GO_LVL) begin m_stop = 0; m_req = 1; end
      pop  = out_ready && sz > 0;
      push = in_valid && sz < DEPTH;
      if (in_valid && !push) m_ovf = 1;
      if (pop) void'(q.pop_front());
      if (push) q.push_back(in_flit);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk(out_valid == (q.size() > 0), "R3 out_valid", out_valid, q.size() > 0);
    if (q.size() > 0) chk(out_flit == q[0], "R2 out_flit order", out_flit, q[0]);
    if (m_req) chk(ctl_req == 1'b1, m_stop ? "R4 stop request" : "R5 go request", ctl_req, 1);
    else       chk(ctl_req == 1'b0, "R6 no repeated request", ctl_req, 0);
    chk(ctl_stop == m_stop, "R6 link state", ctl_stop, m_stop);
    chk(ovf == m_ovf, "R7 overflow flag", ovf, m_ovf);
    if (ctl_req) reqs_seen++;
  endtask

  task automatic step(input bit v, input bit r);
    @(negedge clk);
    compare();
    in_valid  = v;
    out_ready = r;
    if (v) begin in_flit = seq; seq = seq + 8'd1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    // R1 idle state
    chk(!out_valid && !ctl_req && !ctl_stop && !ovf, "R1 reset state",
        {out_valid, ctl_req, ctl_stop, ovf}, 0);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // fill past stop mark, keep pushing into a full buffer (R4, R7)
    reqs_seen = 0;
    for (int i = 0; i < 90; i++) step(1, 0);
    step(0, 0); step(0, 0);
    chk(reqs_seen == 1, "R6 single stop pulse", reqs_seen, 1);
    chk(ovf == 1'b1, "R7 overflow after full", ovf, 1);
    // drain below go mark (R5), flag stays set
    reqs_seen = 0;
    for (int i = 0; i < 85; i++) step(0, 1);
    chk(reqs_seen == 1, "R6 single go pulse", reqs_seen, 1);
    chk(ovf == 1'b1, "R7 overflow sticky", ovf, 1);
    do_reset();
    // sit exactly at stop mark, push and pop together (R8), then one more push
    for (int i = 0; i < STOP_LVL; i++) step(1, 0);
    reqs_seen = 0;
    for (int i = 0; i < 50; i++) step(1, 1);
    step(0, 0);
    chk(reqs_seen == 0, "R8 occupancy steady", reqs_seen, 0);
    step(1, 0); step(0, 0); step(0, 0);
    chk(ctl_stop == 1'b1 && reqs_seen == 1, "R4 stop after one more", ctl_stop, 1);
    for (int i = 0; i < 60; i++) step(0, 1);
    // random traffic across both thresholds
    for (int ph = 0; ph < 12; ph++) begin
      int pv = (ph % 2 == 0) ? 85 : 30;
      int pr = (ph % 2 == 0) ? 40 : 90;
      for (int i = 0; i < 300; i++)
        step(($urandom % 100) < pv, ($urandom % 100) < pr);
    end
    do_reset();
    for (int i = 0; i < 20; i++) step(($urandom % 2) == 1, ($urandom % 2) == 1);
    step(0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule